// File: doc/BRIEF.md
# Bitstream Decimation Filter

This block turns the one-bit output of an oversampling modulator into multi-bit words at a lower rate. It runs a second-order sinc filter: two running-sum stages at the bit rate, then two difference stages at the word rate. Each accepted bit is read as a step of +1 for a one and -1 for a zero. After every K accepted bits the block emits one two's-complement word. The word measures the ones density of the recent stream, so it follows the DC level that the modulator encodes.

The ratio K is taken from the `ratio` pin whenever the filter is reset or restarted. A restart empties every stage. The filter needs a history of two full output periods, so the first two words after a restart carry a cleared settled flag. A consumer that needs valid data can drop those words or wait on the flag.

Stream rules: the input side has no ready signal. A bit is taken on every clock edge where `in_valid` is high and no restart or reset is active. The block never applies back-pressure. The output side is a valid-only stream, and the consumer must take each `out_valid` pulse when it appears.

Top module: `bitstream_decimator`

## Requirements
- R1: While `rst_n` is low, and after it is released until a word is produced, `out_valid`, `out_settled` and `out_data` are all 0.
- R2: `out_valid` is a one-cycle pulse. It appears on the clock edge that accepts every K-th bit since restart, so with an unbroken input stream consecutive pulses are exactly K cycles apart.
- R3: A stream that alternates between 1 and 0 gives a settled word of 0, the mid-scale two's-complement code.
- R4: A settled word from an all-ones stream is +K*K and from an all-zeros stream is -K*K. No word ever leaves the range [-K*K, +K*K], including at K = 256 with an 18-bit word.
- R5: A stream whose pattern period divides K, with ones density d, gives settled words equal to K*K*(2d-1). For example, pattern 1110 gives +K*K/2 and pattern 1000 gives -K*K/2.
- R6: The first two words after a restart or reset have `out_settled` = 0. Every later word has `out_settled` = 1.
- R7: Cycles with `in_valid` low have no effect, whatever value `in_bit` holds.
- R8: A restart clears every filter stage, the bit counter and the word count, and loads a new ratio. A bit offered in the restart cycle is dropped. A partly collected word is discarded.
- R9: A `ratio` value below 2 is used as 2, and a value above 256 is used as 256.
- R10: For a constant stream with step s (+1 or -1), the first word after restart is s*K*(K+1)/2 and the second is s*K*K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous restart; clears state and loads `ratio` |
| ratio | input | 9 | Decimation ratio K, clamped to 2..256 |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | Modulator bit (1 = +1 step, 0 = -1 step) |
| out_valid | output | 1 | One-cycle pulse marking a new word |
| out_data | output | 18 | Output word, two's complement |
| out_settled | output | 1 | Word has a full filter history since restart |

## Verification
The bench checks the two start-up words of constant streams against their exact partial-sum values. A design that delayed or advanced the settled flag, or that did not clear the difference stages on restart, would produce the wrong first and second words or raise the flag on the wrong word. A restart that coincides with a valid opposite bit is also covered. If that bit were absorbed, every following word would be off by a fixed amount. Ratios at 1, 2 and above 256 test both the clamp and the word range at K = 256, where a too-narrow adder would wrap +65536 to a negative code. Idle cycles carrying a noisy `in_bit` are mixed into a density test. A design that counted those cycles would shift both the word values and the pulse spacing.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int MIN_RATIO = 2;

  // Signed step for one modulator bit: +1 for a one, -1 for a zero.
  function automatic logic [1:0] bit_step(input logic b);
    return b ? 2'b01 : 2'b11;
  endfunction
endpackage

// File: rtl/sinc_acc.sv
module sinc_acc #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dnext
);
  logic [W-1:0] acc;

  // Wrap-around running sum; the difference stages undo the wrap.
  assign dnext = acc + din;

  always_ff @(posedge clk) begin
    if (clear)   acc <= '0;
    else if (en) acc <= dnext;
  end
endmodule

// File: rtl/sinc_diff.sv
module sinc_diff #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] prev;

  assign dout = din - prev;

  always_ff @(posedge clk) begin
    if (clear)   prev <= '0;
    else if (en) prev <= din;
  end
endmodule

// File: rtl/dec_phase.sv
module dec_phase #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          clear,
  input  logic          en,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (clear)   cnt <= '0;
    else if (en) cnt <= tick ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/settle_track.sv
module settle_track #(
  parameter int DEPTH = 2,
  parameter int SW    = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic tick,
  output logic full_hist
);
  logic [SW-1:0] words;

  assign full_hist = (words == SW'(DEPTH));

  always_ff @(posedge clk) begin
    if (clear)                   words <= '0;
    else if (tick && !full_hist) words <= words + SW'(1);
  end
endmodule

// File: rtl/bitstream_decimator.sv
module bitstream_decimator #(
  parameter  int KMAX  = 256,
  parameter  int ORDER = 2,
  localparam int RW    = $clog2(KMAX) + 1,
  localparam int AW    = ORDER * $clog2(KMAX) + 2,
  localparam int SW    = $clog2(ORDER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [RW-1:0] ratio,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          out_valid,
  output logic [AW-1:0] out_data,
  output logic          out_settled
);
  import decim_pkg::*;

  logic          clear;
  logic          accept;
  logic          tick;
  logic          full_hist;
  logic [RW-1:0] ratio_q;
  logic [AW-1:0] ichain [0:ORDER];
  logic [AW-1:0] cchain [0:ORDER];

  assign clear  = !rst_n || restart;
  assign accept = in_valid && !clear;

  always_ff @(posedge clk) begin
    if (clear) begin
      if (ratio < RW'(MIN_RATIO))  ratio_q <= RW'(MIN_RATIO);
      else if (ratio > RW'(KMAX))  ratio_q <= RW'(KMAX);
      else                         ratio_q <= ratio;
    end
  end

  assign ichain[0] = AW'($signed(bit_step(in_bit)));

  for (genvar g = 0; g < ORDER; g++) begin : g_integ
    sinc_acc #(.W(AW)) u_acc (
      .clk   (clk),
      .clear (clear),
      .en    (accept),
      .din   (ichain[g]),
      .dnext (ichain[g+1])
    );
  end

  dec_phase #(.CW(RW)) u_phase (
    .clk   (clk),
    .clear (clear),
    .en    (accept),
    .limit (ratio_q),
    .tick  (tick)
  );

  assign cchain[0] = ichain[ORDER];

  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    sinc_diff #(.W(AW)) u_diff (
      .clk   (clk),
      .clear (clear),
      .en    (tick),
      .din   (cchain[g]),
      .dout  (cchain[g+1])
    );
  end

  settle_track #(.DEPTH(ORDER), .SW(SW)) u_settle (
    .clk       (clk),
    .clear     (clear),
    .tick      (tick),
    .full_hist (full_hist)
  );

  always_ff @(posedge clk) begin
    if (clear) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_settled <= 1'b0;
    end else begin
      out_valid <= tick;
      if (tick) begin
        out_data    <= cchain[ORDER];
        out_settled <= full_hist;
      end
    end
  end
endmodule

// File: rtl/decim_checker.sv
module decim_checker #(
  parameter int KMAX  = 256,
  parameter int ORDER = 2,
  parameter int AW    = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          in_valid,
  input logic          out_valid,
  input logic [AW-1:0] out_data,
  input logic          out_settled
);
  localparam longint LIM = longint'(KMAX) * longint'(KMAX);
  int seen;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)            seen <= 0;
    else if (out_valid && seen < ORDER) seen <= seen + 1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && !out_settled);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);

  // R7
  word_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_data)) <= LIM && longint'($signed(out_data)) >= -LIM));

  // R6
  settled_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_settled == (seen == ORDER)));

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !out_valid);
endmodule

bind bitstream_decimator decim_checker #(.KMAX(KMAX), .ORDER(ORDER), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_settled (out_settled)
);

// File: tb/sim_bitstream_decimator.sv
module sim_bitstream_decimator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic [8:0]  ratio = 9'd8;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        out_valid;
  logic [17:0] out_data;
  logic        out_settled;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int last_cyc = 0;
  bit done   = 0;

  int    exp_val [$];
  bit    exp_chk [$];
  bit    exp_set [$];
  int    exp_gap [$];
  string exp_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitstream_decimator u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .ratio(ratio),
    .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_data(out_data), .out_settled(out_settled)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic bit pat_bit(input int pat, input int n);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (n % 2) == 0;
      3: return (n % 4) != 3;
      default: return (n % 4) == 0;
    endcase
  endfunction

  function automatic int pat_ones4(input int pat);
    case (pat)
      2: return 2;
      3: return 3;
      default: return 1;
    endcase
  endfunction

  // Monitor: pops one expected word per output pulse.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_val.size() == 0) begin
        check(1'b0, "R2", "unexpected word", int'($signed(out_data)), 0);
      end else begin
        int v; bit c; bit s; int g; string t;
        v = exp_val.pop_front(); c = exp_chk.pop_front(); s = exp_set.pop_front();
        g = exp_gap.pop_front(); t = exp_tag.pop_front();
        if (c) check(int'($signed(out_data)) == v, t, "word value", int'($signed(out_data)), v);
        check(out_settled == s, "R6", "settled flag", int'(out_settled), int'(s));
        if (g != 0) check(cyc - last_cyc == g, "R2", "pulse spacing", cyc - last_cyc, g);
      end
      last_cyc = cyc;
    end
  end

  task automatic do_restart(input int r, input bit vbit, input bit bval);
    @(negedge clk);
    restart = 1'b1; ratio = 9'(r); in_valid = vbit; in_bit = bval;
    @(negedge clk);
    restart = 1'b0; in_valid = 1'b0;
  endtask

  // Driver: queues the expected words, then feeds the stream.
  task automatic run_case(input string tag, input int r, input int kk, input int pat,
                          input int nwords, input int extra, input bit gaps,
                          input bit vrestart);
    do_restart(r, vrestart, pat == 0);
    for (int w = 1; w <= nwords; w++) begin
      int v; bit c;
      if (pat <= 1) begin
        int s = (pat == 1) ? 1 : -1;
        v = (w == 1) ? s * kk * (kk + 1) / 2 : s * kk * kk;
        c = 1'b1;
      end else begin
        v = kk * kk * (2 * pat_ones4(pat) - 4) / 4;
        c = (w > 2);
      end
      exp_val.push_back(v); exp_chk.push_back(c); exp_set.push_back(w > 2);
      exp_gap.push_back((!gaps && w > 1) ? kk : 0); exp_tag.push_back(tag);
    end
    for (int n = 0; n < nwords * kk + extra; n++) begin
      if (gaps && (n % 3 == 1)) begin
        in_valid = 1'b0; in_bit = ~pat_bit(pat, n);
        @(negedge clk);
      end
      in_valid = 1'b1; in_bit = pat_bit(pat, n);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_val.size() == 0, tag, "words outstanding", exp_val.size(), 0);
    while (exp_val.size() > 0) begin
      void'(exp_val.pop_front()); void'(exp_chk.pop_front()); void'(exp_set.pop_front());
      void'(exp_gap.pop_front()); void'(exp_tag.pop_front());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_settled == 1'b0, "R1", "out_settled in reset", int'(out_settled), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1", "idle after reset",
          int'($signed(out_data)), 0);

    run_case("R3", 8, 8, 2, 5, 0, 1'b0, 1'b0);      // alternating -> 0
    run_case("R4_R10", 16, 16, 1, 4, 0, 1'b0, 1'b0); // all ones
    run_case("R8", 16, 16, 0, 4, 0, 1'b0, 1'b1);    // zeros, bit in restart dropped
    run_case("R5_R7", 8, 8, 3, 5, 0, 1'b1, 1'b0);   // 1110 with idle gaps
    run_case("R5", 8, 8, 4, 5, 0, 1'b0, 1'b0);      // 1000
    run_case("R9", 1, 2, 1, 4, 0, 1'b0, 1'b0);      // ratio 1 -> 2
    run_case("R4_R9", 300, 256, 1, 3, 0, 1'b0, 1'b0); // ratio 300 -> 256
    run_case("R8", 8, 8, 1, 1, 4, 1'b0, 1'b0);      // partial word left behind
    run_case("R8", 4, 4, 1, 3, 0, 1'b0, 1'b0);      // new run starts clean
    run_case("R4", 256, 256, 0, 3, 0, 1'b0, 1'b0);  // negative full scale

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule